// File: doc/BRIEF.md
# Dual External Interrupt Edge Detector

This block turns two asynchronous interrupt pins into clean one-cycle interrupt requests. One pin is a general-purpose interrupt input and the other carries a vertical-sync signal. Each pin first goes through a two-flop synchronizer. It then goes through a stability filter that accepts a new level only after the level has held for longer than a fixed time of about one microsecond. The accepted level is kept in a per-pin level latch. An edge detector watches this latch and raises a request on the edge that software selects for that pin.

A 4-bit register port gives software access to three registers. The first is a packed edge-select register. The second is a read-only level-readback register that shows both filtered pin levels. The third is a 3-bit minimum-width setting that applies only to the general pin. Each step of that setting lengthens the stable time the general pin needs before a change is accepted. The vertical-sync pin always uses only the fixed rejection time.

Top module: `extint_edge_unit`

## Requirements
- R1: The two pins are handled independently. Activity on the general pin (`pin_gen`) only ever affects `irq_gen` and level bit 0. Activity on the sync pin (`pin_vs`) only ever affects `irq_vs` and level bit 2.
- R2: Each request output is high for exactly one clock cycle each time the pin's filtered level changes in the selected direction. An edge-select bit of 0 means a low-to-high change and 1 means a high-to-low change. A change in the other direction gives no request.
- R3: The edge-select register sits at address 0x1F. Bit 0 selects the edge for the general pin and bit 2 selects it for the sync pin. Bits 1 and 3 read 0 and ignore writes, and any address that is not mapped reads 0.
- R4: The level register sits at address 0x0F. Bit 0 holds the general pin's filtered level and bit 2 holds the sync pin's; the other bits read 0. Writes to this address change neither the levels nor any other register.
- R5: With a minimum-width setting of 0, a synchronized pulse of BASE_CYC clock cycles or fewer is rejected. It changes no level and raises no request. A pulse of BASE_CYC+1 cycles is accepted. The sync pin always uses this rule.
- R6: The width register sits at address 0x17 and holds the setting w in bits 2:0; bit 3 reads 0. The general pin needs BASE_CYC+1+w*STEP_CYC stable cycles before a change is accepted. The sync pin is not affected by w.
- R7: Writing a different edge-select value never produces a request by itself.
- R8: After reset both edge-select bits are 0, the width is 0, both levels read 0, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_gen | input | 1 | General interrupt pin, asynchronous |
| pin_vs | input | 1 | Vertical-sync interrupt pin, asynchronous |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data of the addressed register, combinational |
| irq_gen | output | 1 | One-cycle request from the general pin |
| irq_vs | output | 1 | One-cycle request from the sync pin |

## Verification
The bench builds the block with BASE_CYC=4 and STEP_CYC=3. At these values the one-microsecond threshold is a pulse of 4 cycles against one of 5, and a width setting of 2 moves the general pin's threshold to 10 against 11 cycles. Both acceptance limits can therefore be probed exactly, one cycle apart, in a short run. The bench also sets the two pins to different thresholds at the same time, which shows that the width setting reaches only the general pin.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Number of consecutive differing samples needed to accept a new level.
  function automatic int unsigned accept_cycles(input int unsigned base_cyc,
                                                input int unsigned step_cyc,
                                                input logic [2:0]  width);
    return base_cyc + 1 + step_cyc * int'(width);
  endfunction

  // Counter width large enough for the worst-case threshold.
  function automatic int unsigned count_bits(input int unsigned base_cyc,
                                             input int unsigned step_cyc);
    return $clog2(base_cyc + 2 + 7 * step_cyc);
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/extint_filter.sv
module extint_filter
  import extint_pkg::*;
#(
  parameter int unsigned BASE_CYC = 250,
  parameter int unsigned STEP_CYC = 250,
  parameter bit          HAS_PROG = 1'b1,
  parameter int unsigned CNT_W    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [2:0] min_w,
  output logic       level
);
  logic [CNT_W-1:0] need_c;
  logic [CNT_W-1:0] run_q;
  logic             differs;
  logic             accept;

  generate
    if (HAS_PROG) begin : g_prog
      assign need_c = CNT_W'(accept_cycles(BASE_CYC, STEP_CYC, min_w));
    end else begin : g_fixed
      logic [2:0] unused_w;
      assign unused_w = min_w;
      assign need_c   = CNT_W'(accept_cycles(BASE_CYC, 0, 3'd0));
    end
  endgenerate

  assign differs = (din != level);
  assign accept  = differs && (run_q >= need_c - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      level <= 1'b0;
    end else if (!differs) begin
      run_q <= '0;
    end else if (accept) begin
      run_q <= '0;
      level <= din;
    end else begin
      run_q <= run_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/extint_edge.sv
module extint_edge
  import extint_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  edge_sel_e sel,
  output logic      irq
);
  logic level_q;
  logic went_up;
  logic went_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign went_up   = level & ~level_q;
  assign went_down = ~level & level_q;
  assign irq       = (sel == EDGE_FALL) ? went_down : went_up;
endmodule

// File: rtl/extint_edge_unit.sv
module extint_edge_unit
  import extint_pkg::*;
#(
  parameter int unsigned BASE_CYC   = 250,
  parameter int unsigned STEP_CYC   = 250,
  parameter logic [4:0]  EDGE_ADDR  = 5'h1F,
  parameter logic [4:0]  LEVEL_ADDR = 5'h0F,
  parameter logic [4:0]  WIDTH_ADDR = 5'h17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_gen,
  input  logic       pin_vs,
  input  logic [4:0] reg_addr,
  input  logic       reg_wr,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  output logic       irq_gen,
  output logic       irq_vs
);
  localparam int unsigned CNT_W = count_bits(BASE_CYC, STEP_CYC);

  edge_sel_e  sel_gen_q, sel_vs_q;
  logic [2:0] width_q;
  logic       gen_sync, vs_sync;
  logic       gen_level, vs_level;
  logic       wr_edge, wr_width;

  assign wr_edge  = reg_wr && (reg_addr == EDGE_ADDR);
  assign wr_width = reg_wr && (reg_addr == WIDTH_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_gen_q <= EDGE_RISE;
      sel_vs_q  <= EDGE_RISE;
      width_q   <= '0;
    end else begin
      if (wr_edge) begin
        sel_gen_q <= edge_sel_e'(reg_wdata[0]);
        sel_vs_q  <= edge_sel_e'(reg_wdata[2]);
      end
      if (wr_width) width_q <= reg_wdata[2:0];
    end
  end

  always_comb begin
    reg_rdata = 4'h0;
    unique case (reg_addr)
      EDGE_ADDR:  reg_rdata = {1'b0, sel_vs_q, 1'b0, sel_gen_q};
      LEVEL_ADDR: reg_rdata = {1'b0, vs_level, 1'b0, gen_level};
      WIDTH_ADDR: reg_rdata = {1'b0, width_q};
      default:    reg_rdata = 4'h0;
    endcase
  end

  extint_sync #(.STAGES(2)) u_sync_gen (
    .clk(clk), .rst_n(rst_n), .din(pin_gen), .dout(gen_sync));
  extint_sync #(.STAGES(2)) u_sync_vs (
    .clk(clk), .rst_n(rst_n), .din(pin_vs), .dout(vs_sync));

  extint_filter #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC),
                  .HAS_PROG(1'b1), .CNT_W(CNT_W)) u_filt_gen (
    .clk(clk), .rst_n(rst_n), .din(gen_sync), .min_w(width_q),
    .level(gen_level));
  extint_filter #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC),
                  .HAS_PROG(1'b0), .CNT_W(CNT_W)) u_filt_vs (
    .clk(clk), .rst_n(rst_n), .din(vs_sync), .min_w(width_q),
    .level(vs_level));

  extint_edge u_edge_gen (
    .clk(clk), .rst_n(rst_n), .level(gen_level), .sel(sel_gen_q), .irq(irq_gen));
  extint_edge u_edge_vs (
    .clk(clk), .rst_n(rst_n), .level(vs_level), .sel(sel_vs_q), .irq(irq_vs));
endmodule

// File: rtl/extint_edge_unit_chk.sv
module extint_edge_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_gen,
  input logic       irq_vs,
  input logic [3:0] reg_rdata,
  input logic       gen_sync,
  input logic       vs_sync,
  input logic       gen_level,
  input logic       vs_level,
  input logic       sel_gen,
  input logic       sel_vs
);
  // R2: requests last a single cycle
  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gen |=> !irq_gen);
  p_irq_vs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vs |=> !irq_vs);

  // R5: a level only moves to a value the synchronizer held on the previous cycle too
  p_level_follows_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_level) |-> (gen_level == $past(gen_sync)));
  p_vs_level_follows_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vs_level) |-> (vs_level == $past(vs_sync)));

  // R7: a select change with a steady level gives no request
  p_sel_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_gen) && $stable(gen_level)) |-> !irq_gen);
  p_sel_vs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_vs) && $stable(vs_level)) |-> !irq_vs);

  // R3: the top data bit never carries a value
  always @(posedge clk) begin
    if (rst_n) p_bit3_zero_r3: assert (reg_rdata[3] == 1'b0);
  end
endmodule

bind extint_edge_unit extint_edge_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_gen(irq_gen), .irq_vs(irq_vs),
  .reg_rdata(reg_rdata), .gen_sync(gen_sync), .vs_sync(vs_sync),
  .gen_level(gen_level), .vs_level(vs_level),
  .sel_gen(sel_gen_q), .sel_vs(sel_vs_q));

// File: tb/tb_extint_edge_unit.sv
`timescale 1ns/1ps
module tb_extint_edge_unit;
  localparam int unsigned BASE = 4;
  localparam int unsigned STEP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_gen = 1'b0, pin_vs = 1'b0;
  logic [4:0] reg_addr = 5'h00;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic [3:0] reg_rdata;
  logic       irq_gen, irq_vs;

  int n_checks = 0, n_fail = 0;
  int cnt_gen = 0, cnt_vs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extint_edge_unit #(.BASE_CYC(BASE), .STEP_CYC(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .pin_gen(pin_gen), .pin_vs(pin_vs),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_gen(irq_gen), .irq_vs(irq_vs));

  always @(negedge clk) begin
    if (rst_n && irq_gen) cnt_gen++;
    if (rst_n && irq_vs)  cnt_vs++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [3:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Drive a high pulse of w cycles on one pin, then let it settle.
  task automatic pulse(input bit on_vs, input int w);
    @(negedge clk);
    if (on_vs) pin_vs = 1'b1; else pin_gen = 1'b1;
    repeat (w) @(negedge clk);
    if (on_vs) pin_vs = 1'b0; else pin_gen = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [3:0] d;
    rd(5'h1F, d); check(d == 4'h0, "R8 edge reg", d, 0);
    rd(5'h0F, d); check(d == 4'h0, "R8 level reg", d, 0);
    rd(5'h17, d); check(d == 4'h0, "R8 width reg", d, 0);
    check(cnt_gen == 0 && cnt_vs == 0, "R8 no irq", cnt_gen + cnt_vs, 0);
  endtask

  task automatic t_base_filter();
    int g0, v0;
    logic [3:0] d;
    g0 = cnt_gen; pulse(1'b0, BASE);
    check(cnt_gen == g0, "R5 gen short pulse rejected", cnt_gen - g0, 0);
    rd(5'h0F, d); check(d == 4'h0, "R5 level unchanged", d, 0);
    g0 = cnt_gen; v0 = cnt_vs; pulse(1'b0, BASE + 1);
    check(cnt_gen - g0 == 1, "R5 gen pulse accepted", cnt_gen - g0, 1);
    check(cnt_vs == v0, "R1 vs untouched by gen", cnt_vs - v0, 0);
    v0 = cnt_vs; pulse(1'b1, BASE);
    check(cnt_vs == v0, "R5 vs short pulse rejected", cnt_vs - v0, 0);
    v0 = cnt_vs; g0 = cnt_gen; pulse(1'b1, BASE + 1);
    check(cnt_vs - v0 == 1, "R5 vs pulse accepted", cnt_vs - v0, 1);
    check(cnt_gen == g0, "R1 gen untouched by vs", cnt_gen - g0, 0);
  endtask

  task automatic t_registers();
    logic [3:0] d;
    wr(5'h1F, 4'hF); rd(5'h1F, d);
    check(d == 4'h5, "R3 edge reg unused bits", d, 5);
    wr(5'h1F, 4'h0); rd(5'h1F, d);
    check(d == 4'h0, "R3 edge reg clear", d, 0);
    rd(5'h03, d); check(d == 4'h0, "R3 unmapped reads 0", d, 0);
    wr(5'h17, 4'hF); rd(5'h17, d);
    check(d == 4'h7, "R6 width reg bit3", d, 7);
    wr(5'h17, 4'h0);
  endtask

  task automatic t_falling_and_level();
    int g0;
    logic [3:0] d;
    wr(5'h1F, 4'h1);
    g0 = cnt_gen;
    @(negedge clk); pin_gen = 1'b1;
    repeat (20) @(negedge clk);
    check(cnt_gen == g0, "R2 falling select ignores rise", cnt_gen - g0, 0);
    rd(5'h0F, d); check(d == 4'h1, "R4 gen level high", d, 1);
    wr(5'h0F, 4'hA); rd(5'h0F, d);
    check(d == 4'h1, "R4 level write ignored", d, 1);
    rd(5'h1F, d); check(d == 4'h1, "R4 write left edge reg", d, 1);
    // R7: toggle selects while level steady high
    g0 = cnt_gen;
    wr(5'h1F, 4'h0); wr(5'h1F, 4'h5); wr(5'h1F, 4'h0); wr(5'h1F, 4'h1);
    repeat (3) @(negedge clk);
    check(cnt_gen == g0, "R7 select change no irq", cnt_gen - g0, 0);
    @(negedge clk); pin_gen = 1'b0;
    repeat (20) @(negedge clk);
    check(cnt_gen - g0 == 1, "R2 falling edge irq", cnt_gen - g0, 1);
    rd(5'h0F, d); check(d == 4'h0, "R4 gen level low", d, 0);
    wr(5'h1F, 4'h0);
  endtask

  task automatic t_width();
    int g0, v0;
    wr(5'h17, 4'h2);
    g0 = cnt_gen; pulse(1'b0, BASE + 2 * STEP);
    check(cnt_gen == g0, "R6 gen below threshold", cnt_gen - g0, 0);
    g0 = cnt_gen; pulse(1'b0, BASE + 1 + 2 * STEP);
    check(cnt_gen - g0 == 1, "R6 gen at threshold", cnt_gen - g0, 1);
    v0 = cnt_vs; pulse(1'b1, BASE + 1);
    check(cnt_vs - v0 == 1, "R6 vs ignores width", cnt_vs - v0, 1);
    wr(5'h17, 4'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_base_filter();
    t_registers();
    t_falling_and_level();
    t_width();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule